// File: doc/BRIEF.md
# Comma-Aligned 10-Bit Deserializer

This block turns a retimed serial bit stream into 10-bit parallel words. One bit arrives on each rising edge of the bit clock, taken from one of two serial inputs picked by a select pin. Bits fill each word in arrival order, so the earliest bit of a word sits in bit 0 of the output.

When framing is on, the block watches the last ten bits for the start of a positive-running-disparity comma. Its arrival order is 0,0,1,1,1,1,1. When the start is found, those ten bits become the next output word at once, and word boundaries then fall every ten bits from that point. A comma-detect output flags a complete positive-disparity K28.5 character on the output while framing is on. When framing is off, the block emits a word every ten bits with no alignment and reports no commas.

Each output update is marked by a rising edge on one of two complementary word strobes. Each strobe runs at half the word rate, so the rising edges alternate between the two strobes.

Top module: `comma_deser`

## Requirements
- R1: With `sel` low the word stream is built from `rx0`; with `sel` high it is built from `rx1`.
- R2: With `frame_en` low, a word is emitted after every 10 received bits, and the first-received bit of each word appears in `word_out[0]`.
- R3: With `frame_en` high, when the ten most recent bits (once at least ten have arrived since reset or a select change) begin, in arrival order, with 0,0,1,1,1,1,1, those ten bits are output at the clock edge of the tenth bit, and later words follow every 10 bits.
- R4: `comma_det` is high exactly while `frame_en` is high and `word_out` equals 10'h17C (arrival order 0011111010, a K28.5 of positive disparity); it drops as soon as `frame_en` falls.
- R5: A comma that falls on the current word boundary causes no shift and no lost word.
- R6: A negative-disparity comma (arrival order 1100000xxx) causes no realignment.
- R7: With `frame_en` low, a comma pattern neither moves the boundary nor raises `comma_det`, even when a K28.5 lands exactly on the output.
- R8: `wclk_a` and `wclk_b` are always complementary. Every output word update coincides with a rising edge of exactly one of them, alternating, and `wclk_a` rises first after reset.
- R9: At a change of `sel`, the bit taken at that edge is the first bit of a new word. Any partial word is discarded, and the next word completes 10 bits later.
- R10: During reset `word_out` is 0, `comma_det` is 0, `wclk_a` is 0 and `wclk_b` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Serial input select (0: rx0, 1: rx1) |
| rx0 | input | 1 | Serial input 0 |
| rx1 | input | 1 | Serial input 1 |
| frame_en | input | 1 | Enables comma alignment and comma reporting |
| word_out | output | 10 | Parallel word, earliest bit in bit 0 |
| comma_det | output | 1 | High while a positive K28.5 is on `word_out` with framing on |
| wclk_a | output | 1 | Half-rate word strobe, rises on alternate updates |
| wclk_b | output | 1 | Complement of `wclk_a` |

## Verification
The embedded properties check four things on every cycle: an output change always comes with a strobe toggle, comma-detect never shows without framing enabled, a select change never produces a word on that edge, and a rising comma-detect under steady framing comes with a word update. Which ten bits form a word, where the boundary lands after a comma, that an on-boundary comma loses nothing, and that negative commas and disabled framing leave the boundary alone can only be shown by the bench's bit streams with known word offsets. Those streams include a one-hot sweep over all ten bit positions.

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         rx0,
  input  logic         rx1,
  input  logic         frame_en,
  output logic [W-1:0] word_out,
  output logic         comma_det,
  output logic         wclk_a,
  output logic         wclk_b
);
  localparam int CW = $clog2(W);
  localparam int PW = 7;
  localparam logic [W-1:0]  K28P   = 10'b0101111100;
  localparam logic [PW-1:0] PREFIX = 7'b1111100;

  logic          bit_in;
  logic [W-1:0]  win, win_nx;
  logic [CW-1:0] cnt;
  logic          primed, sel_q, phase;
  logic          restart, full_word, hit, emit;

  assign bit_in    = sel ? rx1 : rx0;
  assign win_nx    = {bit_in, win[W-1:1]};
  assign restart   = sel != sel_q;
  assign full_word = cnt == CW'(W-1);
  assign hit       = frame_en && (primed || full_word) && (win_nx[PW-1:0] == PREFIX);
  assign emit      = !restart && (full_word || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win      <= '0;
      cnt      <= '0;
      primed   <= 1'b0;
      sel_q    <= 1'b0;
      phase    <= 1'b0;
      word_out <= '0;
    end else begin
      win   <= win_nx;
      sel_q <= sel;
      if (restart) begin
        cnt    <= CW'(1);
        primed <= 1'b0;
      end else if (emit) begin
        cnt      <= '0;
        primed   <= 1'b1;
        word_out <= win_nx;
        phase    <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign comma_det = frame_en && (word_out == K28P);
  assign wclk_a    = phase;
  assign wclk_b    = ~phase;

  // R8
  upd_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_out != $past(word_out)) |-> (wclk_a != $past(wclk_a)));

  // R4
  comma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comma_det |-> frame_en);

  // R9
  sel_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |=> $stable(wclk_a));

  // R3
  comma_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(comma_det) && $stable(frame_en)) |-> (wclk_a != $past(wclk_a)));
endmodule

// File: tb/test_comma_deser.sv
`timescale 1ns/1ps
module test_comma_deser;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, rx0 = 1'b0, rx1 = 1'b0, frame_en = 1'b0;
  logic [9:0] word_out;
  logic comma_det, wclk_a, wclk_b;

  comma_deser i_comma_deser (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rx0(rx0), .rx1(rx1), .frame_en(frame_en),
    .word_out(word_out), .comma_det(comma_det), .wclk_a(wclk_a), .wclk_b(wclk_b)
  );

  always #5 clk = ~clk;

  localparam logic [9:0] KP = 10'h17C;
  localparam logic [9:0] PW = 10'h155;
  localparam logic [9:0] QW = 10'h333;
  localparam logic [9:0] KN = 10'h283;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [9:0] cap_w [0:15];
  logic       cap_c [0:15];
  int ncap = 0;
  logic pa = 1'b0, pb = 1'b1, exp_a = 1'b1;
  bit strm [0:127];
  int st [0:15];
  bit ecd [0:15];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  // R8: strobe monitor and word capture
  always @(negedge clk) begin
    if (rst_n) begin
      if ((wclk_a && !pa) || (wclk_b && !pb)) begin
        chk(wclk_a != wclk_b && wclk_a == exp_a, "R8", {30'd0, wclk_a, wclk_b}, {30'd0, exp_a, ~exp_a});
        exp_a = ~exp_a;
        if (ncap < 16) begin
          cap_w[ncap] = word_out;
          cap_c[ncap] = comma_det;
        end
        ncap++;
      end
      pa = wclk_a;
      pb = wclk_b;
    end
  end

  task automatic do_reset(input bit s, input bit fe);
    @(negedge clk);
    rst_n = 1'b0;
    sel = s;
    frame_en = fe;
    repeat (2) @(negedge clk);
    ncap = 0; pa = 1'b0; pb = 1'b1; exp_a = 1'b1;
    // R10
    chk(word_out == 10'd0 && comma_det == 1'b0 && wclk_a == 1'b0 && wclk_b == 1'b1, "R10",
        {comma_det, wclk_a, wclk_b, word_out}, {3'b001, 10'd0});
    rst_n = 1'b1;
  endtask

  task automatic send(input int n, input bit on1);
    for (int i = 0; i < n; i++) begin
      rx0 = on1 ? ~strm[i] : strm[i];
      rx1 = on1 ? strm[i] : ~strm[i];
      @(negedge clk);
    end
    #1;
  endtask

  task automatic put(input int at, input logic [9:0] w);
    for (int b = 0; b < 10; b++) strm[at+b] = w[b];
  endtask

  task automatic clear_strm();
    for (int i = 0; i < 128; i++) strm[i] = 1'b0;
  endtask

  task automatic check_caps(input int n, input string r);
    chk(ncap == n, r, ncap, n);
    for (int k = 0; k < n && k < 16; k++) begin
      logic [9:0] e;
      for (int b = 0; b < 10; b++) e[b] = strm[st[k]+b];
      chk(cap_w[k] == e, r, cap_w[k], e);
      chk(cap_c[k] == ecd[k], "R4", cap_c[k], ecd[k]);
    end
  endtask

  initial begin
    // R2: one-hot sweep of every bit position, framing off, input 0
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 100; i++) strm[i] = ((i % 10) == (i / 10));
    for (int k = 0; k < 10; k++) begin st[k] = 10 * k; ecd[k] = 1'b0; end
    send(100, 1'b0);
    check_caps(10, "R2");

    // R1: input 1 selected, pseudo pattern, inverse on the other input
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) strm[i] = ((i * i + 3 * i) % 7) < 3;
    for (int k = 0; k < 4; k++) begin st[k] = 10 * k; ecd[k] = 1'b0; end
    send(40, 1'b1);
    check_caps(4, "R1");

    // R3: comma two bits off the current boundary
    do_reset(1'b0, 1'b1);
    clear_strm();
    put(12, KP); put(22, PW); put(32, QW);
    st[0] = 0; st[1] = 10; st[2] = 12; st[3] = 22; st[4] = 32;
    for (int k = 0; k < 5; k++) ecd[k] = (k == 2);
    send(42, 1'b0);
    check_caps(5, "R3");

    // R5: commas on the boundary, then R4 framing drop
    do_reset(1'b0, 1'b1);
    clear_strm();
    put(0, PW); put(10, KP); put(20, KP);
    st[0] = 0; st[1] = 10; st[2] = 20;
    ecd[0] = 1'b0; ecd[1] = 1'b1; ecd[2] = 1'b1;
    send(30, 1'b0);
    check_caps(3, "R5");
    frame_en = 1'b0;
    #1;
    chk(comma_det == 1'b0, "R4", comma_det, 0);
    chk(word_out == KP, "R4", word_out, KP);

    // R6: negative-disparity comma leaves the boundary alone
    do_reset(1'b0, 1'b1);
    clear_strm();
    put(12, KN); put(22, PW); put(32, QW);
    for (int k = 0; k < 4; k++) begin st[k] = 10 * k; ecd[k] = 1'b0; end
    send(42, 1'b0);
    check_caps(4, "R6");

    // R7: framing off, comma aligned and misaligned
    do_reset(1'b0, 1'b0);
    clear_strm();
    put(0, KP); put(10, PW); put(22, KP);
    for (int k = 0; k < 4; k++) begin st[k] = 10 * k; ecd[k] = 1'b0; end
    send(42, 1'b0);
    check_caps(4, "R7");

    // R9: select change after a partial word
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) begin
      rx0 = 1'b1; rx1 = 1'b0;
      @(negedge clk);
    end
    #1;
    chk(ncap == 0, "R9", ncap, 0);
    for (int i = 0; i < 20; i++) strm[i] = ((3 * i + 1) % 4) < 2;
    sel = 1'b1;
    st[0] = 0; st[1] = 10; ecd[0] = 1'b0; ecd[1] = 1'b0;
    send(20, 1'b1);
    check_caps(2, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule